// File: doc/BRIEF.md
# Shift and Rotate Unit

This block moves the bits of an operand of 8, 16 or 32 bits left or right and gives back the moved value together with an updated carry flag. It covers logical and arithmetic shifts in both directions, plain rotates, rotates that pass through the carry flag as a ninth (17th, 33rd) bit of the ring, and double-width shifts. A double-width shift fills the bits freed in the destination from a second source operand, and the source itself is never changed.

An execution pipeline places one request per cycle on the input side with `in_valid`. One clock later the unit returns the result, the new carry and a flag that says whether the carry was actually updated. Shift counts are reduced to their low five bits. A reduced count of zero leaves the operand and the carry as they were. Operand bits above the selected lane width are ignored, and the result is zero there.

Top module: `srot_unit`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high with its result on the next clock edge. `out_valid` is low in every cycle that follows an idle cycle. During reset, `out_valid`, `result`, `carry_out` and `flag_valid` are all 0.
- R2: Operation codes 0 and 1 (left shift) behave identically. Zeros enter at bit 0, and the carry is the last bit pushed out of the top of the lane, or 0 once the count exceeds the lane width.
- R3: Operation code 2 (logical right shift) brings zeros in at the lane's top bit, and the carry is the last bit pushed out of bit 0.
- R4: Operation code 3 (arithmetic right shift) keeps the lane's sign bit and copies it into every freed position. The carry is the last bit pushed out of bit 0. For example, 8'h80 shifted by one gives 8'hC0.
- R5: Operation code 4 rotates left and code 5 rotates right inside the lane. The carry equals the bit that last wrapped around: bit 0 of the result for a left rotate, the lane's top bit for a right rotate. A count equal to the lane width returns the original value.
- R6: Operation codes 6 (left) and 7 (right) rotate the operand and the carry as one ring of lane width plus one bit. The old carry enters at the far end and the bit leaving the operand becomes the new carry. A count of lane width plus one returns both unchanged.
- R7: Operation code 8 (double-width left shift) shifts the destination left and fills its freed low bits from the top bits of the source, taken in order. The carry is the last bit pushed out of the destination. Example: 32'h3456 by 4 with source 32'h1000_0000 gives 32'h34561.
- R8: Operation code 9 (double-width right shift) shifts the destination right and fills its freed top bits from the low bits of the source. The carry is the last bit pushed out of bit 0 of the destination.
- R9: Only the low five bits of `count` are used. When those five bits are zero, the result equals the lane-masked operand, `carry_out` equals `carry_in`, and `flag_valid` is 0. Otherwise `flag_valid` is 1.
- R10: `lane` selects the width: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits. Input bits above the lane width have no effect, and result bits above it are 0.
- R11: Operation codes 10 to 15 return the lane-masked operand with `carry_out` equal to `carry_in` and `flag_valid` 0.
- R12: In cycles without `in_valid`, `result`, `carry_out` and `flag_valid` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (see requirements) |
| lane | input | 2 | Operand width select |
| count | input | 8 | Shift or rotate count, low five bits used |
| dst | input | 32 | Operand to be shifted |
| src | input | 32 | Fill source for the double-width shifts |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Shifted or rotated value, zero above the lane |
| carry_out | output | 1 | Updated carry flag |
| flag_valid | output | 1 | High when the carry was updated (nonzero count, known operation) |

## Verification
The assertions assume that requests arrive only after the internal reset has been released, and that `op`, `lane` and `count` are stable, known values whenever `in_valid` is high. The bench waits several cycles after it deasserts reset and changes every input only on the falling clock edge, so each request is sampled whole. The sweep covers all sixteen operation codes, all four lane codes and every five-bit count. Counts above 31 are also applied, so the masking is exercised while the assertions see only the reduced count.

// File: rtl/srot_pkg.sv
package srot_pkg;

  localparam logic [3:0] OP_SHL  = 4'd0;
  localparam logic [3:0] OP_SAL  = 4'd1;
  localparam logic [3:0] OP_SHR  = 4'd2;
  localparam logic [3:0] OP_SAR  = 4'd3;
  localparam logic [3:0] OP_ROL  = 4'd4;
  localparam logic [3:0] OP_ROR  = 4'd5;
  localparam logic [3:0] OP_RCL  = 4'd6;
  localparam logic [3:0] OP_RCR  = 4'd7;
  localparam logic [3:0] OP_DSHL = 4'd8;
  localparam logic [3:0] OP_DSHR = 4'd9;

  typedef enum logic [1:0] {
    LANE_QUARTER = 2'd0,
    LANE_HALF    = 2'd1,
    LANE_FULL    = 2'd2,
    LANE_FULL_B  = 2'd3
  } lane_e;

  function automatic int unsigned lane_bits(input lane_e sel, input int unsigned full);
    case (sel)
      LANE_QUARTER: return full / 4;
      LANE_HALF:    return full / 2;
      default:      return full;
    endcase
  endfunction

  function automatic logic op_is_rotate(input logic [3:0] code);
    return (code >= OP_ROL) && (code <= OP_RCR);
  endfunction

endpackage

// File: rtl/srot_count_norm.sv
module srot_count_norm #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  localparam int CNT_W   = $clog2(DATA_W),
  localparam int LW_W    = $clog2(DATA_W) + 2
) (
  input  logic [CNT_IN_W-1:0] count_raw,
  input  logic [LW_W-1:0]     lane_w,
  output logic [CNT_W-1:0]    cnt,
  output logic                cnt_zero,
  output logic [CNT_W-1:0]    rot_cnt,
  output logic [CNT_W-1:0]    ring_cnt
);

  // Subtractions needed to fold the largest count into the smallest ring.
  localparam int FOLD_STEPS = (2 ** CNT_W) / (DATA_W / 4 + 1) + 1;

  logic [LW_W-1:0] lane_m1;
  logic [LW_W-1:0] ring_len;
  logic [LW_W-1:0] fold;

  assign cnt      = CNT_W'(count_raw);
  assign cnt_zero = (cnt == '0);
  assign lane_m1  = lane_w - 1'b1;
  assign ring_len = lane_w + 1'b1;
  assign rot_cnt  = cnt & lane_m1[CNT_W-1:0];

  always_comb begin
    fold = LW_W'(cnt);
    for (int i = 0; i < FOLD_STEPS; i++) begin
      if (fold >= ring_len) fold = fold - ring_len;
    end
  end

  assign ring_cnt = fold[CNT_W-1:0];

endmodule

// File: rtl/srot_shift_core.sv
module srot_shift_core
  import srot_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int LW_W  = $clog2(DATA_W) + 2,
  localparam int WIDE  = 4 * DATA_W
) (
  input  logic [3:0]        op,
  input  logic [LW_W-1:0]   lane_w,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res,
  output logic              cy
);

  logic [WIDE-1:0]   a_w, b_w;
  logic [WIDE-1:0]   left_p, right_q, sar_q;
  logic [WIDE-1:0]   dl_pair, dl_z, dr_pair, dr_q, dr_c;
  logic [LW_W-1:0]   lane_x2;
  logic              sign;
  logic [DATA_W-1:0] sx;

  assign a_w     = WIDE'(opa);
  assign b_w     = WIDE'(opb);
  assign lane_x2 = lane_w << 1;
  assign sign    = a_w[lane_w - 1'b1];
  assign sx      = opa | (sign ? ~lane_mask : '0);

  // single shifter per family, result read from a fixed window
  assign left_p  = a_w << cnt;
  assign right_q = (a_w << DATA_W) >> cnt;
  assign sar_q   = {{(WIDE - 2*DATA_W){sign}}, sx, {DATA_W{1'b0}}} >> cnt;

  // double-width: destination and source concatenated at lane width
  assign dl_pair = (a_w << lane_w) | b_w;
  assign dl_z    = dl_pair << cnt;
  assign dr_pair = a_w | (b_w << lane_w);
  assign dr_q    = dr_pair >> cnt;
  assign dr_c    = (dr_pair << 1) >> cnt;

  always_comb begin
    res = opa;
    cy  = 1'b0;
    case (op)
      OP_SHL, OP_SAL: begin
        res = DATA_W'(left_p) & lane_mask;
        cy  = left_p[lane_w];
      end
      OP_SHR: begin
        res = DATA_W'(right_q >> DATA_W);
        cy  = right_q[DATA_W-1];
      end
      OP_SAR: begin
        res = DATA_W'(sar_q >> DATA_W) & lane_mask;
        cy  = sar_q[DATA_W-1];
      end
      OP_DSHL: begin
        res = DATA_W'(dl_z >> lane_w) & lane_mask;
        cy  = dl_z[lane_x2];
      end
      OP_DSHR: begin
        res = DATA_W'(dr_q) & lane_mask;
        cy  = dr_c[0];
      end
      default: begin
        res = opa;
        cy  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/srot_rotate_core.sv
module srot_rotate_core
  import srot_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int LW_W  = $clog2(DATA_W) + 2,
  localparam int WIDE  = 4 * DATA_W
) (
  input  logic [3:0]        op,
  input  logic [LW_W-1:0]   lane_w,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] opa,
  input  logic              carry_in,
  input  logic [CNT_W-1:0]  rot_cnt,
  input  logic [CNT_W-1:0]  ring_cnt,
  output logic [DATA_W-1:0] res,
  output logic              cy
);

  logic [WIDE-1:0] d_w, twin, rol_t, ror_t;
  logic [WIDE-1:0] ring, ring_twin, rcl_t, rcr_t;
  logic [LW_W-1:0] lane_m1, ring_len;

  assign lane_m1  = lane_w - 1'b1;
  assign ring_len = lane_w + 1'b1;
  assign d_w      = WIDE'(opa);

  // two copies side by side make any rotate a plain shift
  assign twin  = (d_w << lane_w) | d_w;
  assign rol_t = (twin << rot_cnt) >> lane_w;
  assign ror_t = twin >> rot_cnt;

  // carry sits just above the lane to form the extended ring
  assign ring      = d_w | (WIDE'(carry_in) << lane_w);
  assign ring_twin = (ring << ring_len) | ring;
  assign rcl_t     = (ring_twin << ring_cnt) >> ring_len;
  assign rcr_t     = ring_twin >> ring_cnt;

  always_comb begin
    res = opa;
    cy  = carry_in;
    case (op)
      OP_ROL: begin
        res = DATA_W'(rol_t) & lane_mask;
        cy  = rol_t[0];
      end
      OP_ROR: begin
        res = DATA_W'(ror_t) & lane_mask;
        cy  = ror_t[lane_m1];
      end
      OP_RCL: begin
        res = DATA_W'(rcl_t) & lane_mask;
        cy  = rcl_t[lane_w];
      end
      OP_RCR: begin
        res = DATA_W'(rcr_t) & lane_mask;
        cy  = rcr_t[lane_w];
      end
      default: begin
        res = opa;
        cy  = carry_in;
      end
    endcase
  end

endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          op,
  input  logic [1:0]          lane,
  input  logic [CNT_IN_W-1:0] count,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  input  logic                carry_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                carry_out,
  output logic                flag_valid
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int LW_W  = $clog2(DATA_W) + 2;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [LW_W-1:0]   lane_w;
  logic [DATA_W-1:0] lane_mask, opa, opb;
  logic [CNT_W-1:0]  cnt, rot_cnt, ring_cnt;
  logic              cnt_zero;
  logic [DATA_W-1:0] sh_res, rt_res;
  logic              sh_cy, rt_cy;

  assign lane_w    = LW_W'(lane_bits(lane_e'(lane), DATA_W));
  assign lane_mask = {DATA_W{1'b1}} >> (DATA_W - int'(lane_w));
  assign opa       = dst & lane_mask;
  assign opb       = src & lane_mask;

  srot_count_norm #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_cnt (
    .count_raw (count),
    .lane_w    (lane_w),
    .cnt       (cnt),
    .cnt_zero  (cnt_zero),
    .rot_cnt   (rot_cnt),
    .ring_cnt  (ring_cnt)
  );

  srot_shift_core #(.DATA_W(DATA_W)) u_shift (
    .op        (op),
    .lane_w    (lane_w),
    .lane_mask (lane_mask),
    .opa       (opa),
    .opb       (opb),
    .cnt       (cnt),
    .res       (sh_res),
    .cy        (sh_cy)
  );

  srot_rotate_core #(.DATA_W(DATA_W)) u_rot (
    .op        (op),
    .lane_w    (lane_w),
    .lane_mask (lane_mask),
    .opa       (opa),
    .carry_in  (carry_in),
    .rot_cnt   (rot_cnt),
    .ring_cnt  (ring_cnt),
    .res       (rt_res),
    .cy        (rt_cy)
  );

  // next-state selection
  logic              op_known;
  logic [DATA_W-1:0] res_d;
  logic              cy_d, fv_d;

  assign op_known = (op <= OP_DSHR);

  always_comb begin
    res_d = opa;
    cy_d  = carry_in;
    fv_d  = 1'b0;
    if (op_known && !cnt_zero) begin
      fv_d = 1'b1;
      if (op_is_rotate(op)) begin
        res_d = rt_res;
        cy_d  = rt_cy;
      end else begin
        res_d = sh_res;
        cy_d  = sh_cy;
      end
    end
  end

  // output registers, loaded only on a request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      carry_out  <= 1'b0;
      flag_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_d;
        carry_out  <= cy_d;
        flag_valid <= fv_d;
      end
    end
  end

endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [3:0]          op,
  input logic [1:0]          lane,
  input logic [CNT_IN_W-1:0] count,
  input logic                carry_in,
  input logic                out_valid,
  input logic [DATA_W-1:0]   result,
  input logic                carry_out,
  input logic                flag_valid
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] cnt_lo;
  assign cnt_lo = CNT_W'(count);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(flag_valid)));

  a_r9_zero_count_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_lo == '0) |=> (!flag_valid && carry_out == $past(carry_in)));

  a_r11_unknown_op_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd9) |=> (!flag_valid && carry_out == $past(carry_in)));

  a_r10_narrow_lane_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane == 2'd0) |=> (result[DATA_W-1:DATA_W/4] == '0));

  a_r5_rol_carry_is_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4 && cnt_lo != '0) |=> (carry_out == result[0]));

  a_r3_shr_full_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2 && lane == 2'd2 && cnt_lo != '0) |=> !result[DATA_W-1]);

  a_r9_flag_when_counting: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= 4'd9 && cnt_lo != '0) |=> flag_valid);

endmodule

bind srot_unit srot_unit_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .op         (op),
  .lane       (lane),
  .count      (count),
  .carry_in   (carry_in),
  .out_valid  (out_valid),
  .result     (result),
  .carry_out  (carry_out),
  .flag_valid (flag_valid)
);

// File: tb/srot_unit_test.sv
module srot_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [1:0]  lane;
  logic [7:0]  count;
  logic [31:0] dst, src;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;
  logic        flag_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srot_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane(lane),
    .count(count), .dst(dst), .src(src), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .flag_valid(flag_valid)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  ln;
    logic [7:0]  cnt;
    logic [31:0] d;
    logic [31:0] s;
    logic        ci;
    logic [31:0] er;
    logic        ec;
    logic        ef;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 2'd0, 8'd1,  32'h81,        32'h0,         1'b0, 32'h02,      1'b1, 1'b1, 4'd2},  // R2
    '{4'd1, 2'd0, 8'd1,  32'h81,        32'h0,         1'b0, 32'h02,      1'b1, 1'b1, 4'd2},  // R2 alias
    '{4'd0, 2'd0, 8'd9,  32'hFF,        32'h0,         1'b1, 32'h00,      1'b0, 1'b1, 4'd2},  // R2 past width
    '{4'd2, 2'd0, 8'd1,  32'h81,        32'h0,         1'b0, 32'h40,      1'b1, 1'b1, 4'd3},  // R3
    '{4'd2, 2'd2, 8'd31, 32'h8000_0001, 32'h0,         1'b1, 32'h1,       1'b0, 1'b1, 4'd3},  // R3
    '{4'd3, 2'd0, 8'd1,  32'h80,        32'h0,         1'b0, 32'hC0,      1'b0, 1'b1, 4'd4},  // R4
    '{4'd3, 2'd1, 8'd4,  32'h8F0F,      32'h0,         1'b0, 32'hF8F0,    1'b1, 1'b1, 4'd4},  // R4
    '{4'd4, 2'd0, 8'd1,  32'h81,        32'h0,         1'b0, 32'h03,      1'b1, 1'b1, 4'd5},  // R5
    '{4'd5, 2'd0, 8'd1,  32'h01,        32'h0,         1'b0, 32'h80,      1'b1, 1'b1, 4'd5},  // R5
    '{4'd4, 2'd0, 8'd8,  32'hA5,        32'h0,         1'b0, 32'hA5,      1'b1, 1'b1, 4'd5},  // R5 full turn
    '{4'd6, 2'd0, 8'd1,  32'h80,        32'h0,         1'b0, 32'h00,      1'b1, 1'b1, 4'd6},  // R6
    '{4'd7, 2'd0, 8'd1,  32'h01,        32'h0,         1'b1, 32'h80,      1'b1, 1'b1, 4'd6},  // R6
    '{4'd6, 2'd0, 8'd9,  32'h5A,        32'h0,         1'b1, 32'h5A,      1'b1, 1'b1, 4'd6},  // R6 full ring
    '{4'd8, 2'd2, 8'd4,  32'h3456,      32'h1000_0000, 1'b0, 32'h34561,   1'b0, 1'b1, 4'd7},  // R7
    '{4'd8, 2'd2, 8'd12, 32'h0,         32'h1230_0000, 1'b1, 32'h123,     1'b0, 1'b1, 4'd7},  // R7
    '{4'd9, 2'd1, 8'd4,  32'h1234,      32'h00AB,      1'b0, 32'hB123,    1'b0, 1'b1, 4'd8},  // R8
    '{4'd0, 2'd0, 8'd33, 32'h81,        32'h0,         1'b0, 32'h02,      1'b1, 1'b1, 4'd9},  // R9 masked count
    '{4'd0, 2'd0, 8'd32, 32'h81,        32'h0,         1'b1, 32'h81,      1'b1, 1'b0, 4'd9},  // R9 zero count
    '{4'd2, 2'd0, 8'd1,  32'hFFFF_FF81, 32'h0,         1'b0, 32'h40,      1'b1, 1'b1, 4'd10}, // R10
    '{4'd12, 2'd2, 8'd3, 32'hDEAD_BEEF, 32'h0,         1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'd11} // R11
  };

  // Bit-serial reference, one step per count.
  function automatic logic [33:0] model(input logic [3:0] o, input logic [1:0] ln,
                                        input logic [7:0] c_in, input logic [31:0] d_in,
                                        input logic [31:0] s_in, input logic ci);
    int w;
    int n;
    logic [31:0] m, d, s;
    logic c, t;
    w = (ln == 2'd0) ? 8 : (ln == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    d = d_in & m;
    s = s_in & m;
    c = ci;
    n = int'(c_in) % 32;
    if (o > 4'd9 || n == 0) return {d, ci, 1'b0};
    for (int i = 0; i < n; i++) begin
      case (o)
        4'd0, 4'd1: begin c = d[w-1]; d = (d << 1) & m; end
        4'd2: begin c = d[0]; d = d >> 1; end
        4'd3: begin c = d[0]; d = (d >> 1) | (d & (32'h1 << (w-1))); end
        4'd4: begin c = d[w-1]; d = ((d << 1) & m) | {31'b0, c}; end
        4'd5: begin c = d[0]; d = (d >> 1) | ({31'b0, c} << (w-1)); end
        4'd6: begin t = d[w-1]; d = ((d << 1) & m) | {31'b0, c}; c = t; end
        4'd7: begin t = d[0]; d = (d >> 1) | ({31'b0, c} << (w-1)); c = t; end
        4'd8: begin c = d[w-1]; d = ((d << 1) & m) | {31'b0, s[w-1]}; s = (s << 1) & m; end
        default: begin c = d[0]; d = (d >> 1) | ({31'b0, s[0]} << (w-1)); s = s >> 1; end
      endcase
    end
    return {d, c, 1'b1};
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2:       return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8:       return "R7";
      4'd9:       return "R8";
      default:    return "R11";
    endcase
  endfunction

  task automatic check3(input string tag, input logic [31:0] er, input logic ec, input logic ef);
    checks++;
    if (out_valid !== 1'b1 || result !== er || carry_out !== ec || flag_valid !== ef) begin
      errors++;
      $display("FAIL %s: got v=%b res=%h c=%b f=%b, expected v=1 res=%h c=%b f=%b",
               tag, out_valid, result, carry_out, flag_valid, er, ec, ef);
    end
  endtask

  // one request, then one idle cycle; outputs read on the falling edge after
  task automatic apply(input logic [3:0] o, input logic [1:0] ln, input logic [7:0] c,
                       input logic [31:0] d, input logic [31:0] s, input logic ci);
    @(negedge clk);
    in_valid = 1'b1; op = o; lane = ln; count = c; dst = d; src = s; carry_in = ci;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [33:0] exp_v;
    logic [31:0] held_r;
    logic        held_c, held_f;
    logic [31:0] operands [4];
    operands[0] = 32'h8000_0001;
    operands[1] = 32'h5A3C_96E1;
    operands[2] = 32'hFFFF_FFFF;
    operands[3] = 32'h0123_4567;

    rst_n = 1'b0; in_valid = 1'b0; op = '0; lane = '0; count = '0;
    dst = '0; src = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || carry_out !== 1'b0 || flag_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b res=%h c=%b f=%b, expected all zero",
               out_valid, result, carry_out, flag_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].op, VECS[k].ln, VECS[k].cnt, VECS[k].d, VECS[k].s, VECS[k].ci);
      check3($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].er, VECS[k].ec, VECS[k].ef);
    end

    // R12: idle cycle keeps outputs, R1: out_valid drops
    apply(4'd3, 2'd2, 8'd7, 32'h9000_0000, 32'h0, 1'b0);
    held_r = result; held_c = carry_out; held_f = flag_valid;
    op = 4'd0; count = 8'd5; dst = 32'h1234_5678; carry_in = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== held_r || carry_out !== held_c || flag_valid !== held_f) begin
      errors++;
      $display("FAIL R12 hold: got v=%b res=%h c=%b f=%b, expected v=0 res=%h c=%b f=%b",
               out_valid, result, carry_out, flag_valid, held_r, held_c, held_f);
    end

    // R1 back-to-back requests
    @(negedge clk);
    in_valid = 1'b1; op = 4'd2; lane = 2'd0; count = 8'd2; dst = 32'hF0; carry_in = 1'b0;
    @(negedge clk);
    check3("R1 first of pair", 32'h3C, 1'b0, 1'b1);
    op = 4'd0; count = 8'd4; dst = 32'hF0;
    @(negedge clk);
    in_valid = 1'b0;
    check3("R1 second of pair", 32'h00, 1'b1, 1'b1);

    // Sweep against the serial reference: all ops, lanes, counts
    for (int o = 0; o < 16; o++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int c = 0; c < 32; c++) begin
          for (int v = 0; v < 4; v++) begin
            logic [7:0] cv;
            cv = (v == 3) ? 8'(c + 64) : 8'(c);
            exp_v = model(4'(o), 2'(ln), cv, operands[v], 32'hC3A5_0F69 ^ operands[v], v[0]);
            apply(4'(o), 2'(ln), cv, operands[v], 32'hC3A5_0F69 ^ operands[v], v[0]);
            check3($sformatf("%s sweep op=%0d lane=%0d cnt=%0d", op_tag(4'(o)), o, ln, cv),
                   exp_v[33:2], exp_v[1], exp_v[0]);
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got no completion, expected finish within limit");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule